// File: doc/BRIEF.md
# Interrupt Bypass and Priority Selector

This block sits between a set of peripheral interrupt request lines and a small coprocessor. Each request line has a bypass control bit. A bypassed line goes straight out on its matching interrupt output, for the main processor to handle, and the coprocessor never sees it. A line whose bypass bit is clear is hidden from that output and offered to a priority encoder instead. The encoder names the one channel the coprocessor should service next.

Channel numbering starts at 1. Index 0 does not exist, so the encoder never reports channel 0 as a valid choice. After reset every channel is bypassed, which means the coprocessor receives no requests until software hands channels over to it. Software clears bypass bits through a simple write port with byte-lane enables. Among the handed-over channels that are requesting, the lowest channel number wins. The selection and its valid flag are registered.

Top module: `irq_bypass_sel`

## Requirements
- R1: While `rst_n` is low at a clock edge, every bypass bit is set to 1 and the selection register is cleared. After reset, `irq_out` equals `irq_in`, `sel_valid` is 0 and `sel_ch` is 0.
- R2: At any time, `irq_out[c]` equals `irq_in[c]` when the bypass bit of channel c is 1, and is 0 when that bit is 0.
- R3: A channel whose bypass bit is 1 is never reported on `sel_ch` while `sel_valid` is 1, even if its request is active.
- R4: Among the channels whose request is high and whose bypass bit is 0, `sel_ch` reports the lowest channel number.
- R5: When no channel has its request high and its bypass bit at 0, `sel_valid` is 0 and `sel_ch` is 0.
- R6: A write with `wr_en` high loads the bypass bit of channel c from `wr_data[c-1]`, but only when `wr_be[(c-1)/8]` is high. A 1 sets bypass and a 0 clears it. Channels in lanes whose enable is low keep their bits.
- R7: When `wr_en` is low, no bypass bit changes, whatever `wr_be` and `wr_data` hold.
- R8: `sel_valid` and `sel_ch` reflect the requests and bypass bits that were present at the previous clock edge. A bypass write taken at an edge reaches `irq_out` right after that edge and reaches `sel_ch` at the following edge.
- R9: Whenever `sel_valid` is 1, `sel_ch` lies between 1 and NUM_CH. Channel number 0 is never reported as valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for the bypass register |
| wr_be | input | LANES | Byte-lane enables; lane k covers channels 8k+1 to 8k+8 |
| wr_data | input | 8*LANES | New bypass values; bit c-1 belongs to channel c |
| irq_in | input | NUM_CH (NUM_CH:1) | Incoming request lines, channels 1 to NUM_CH |
| irq_out | output | NUM_CH (NUM_CH:1) | Bypassed requests forwarded to the main processor |
| sel_valid | output | 1 | A channel is selected for the coprocessor (registered) |
| sel_ch | output | CH_W | Selected channel number, 0 when none (registered) |

## Verification
The bench first drives requests while every channel is still in its reset bypass state. This shows that forwarding works and that the encoder stays silent. It then hands over one byte lane at a time. Requests that straddle a handed-over lane and a bypassed lane show that masking acts per channel on both paths, and that a lane whose enable is low, or a write with the strobe low, leaves the bits alone. The priority check uses request sets that pit a low channel against a higher one, sets with a single request at the lane edges (channels 1, 8, 9 and 16), and the empty set. Each set gives a different winner, so a reversed or off-by-one encoder shows up. Latency is tested by changing a request or a bypass bit and reading the outputs both before and after the next edge.

// File: rtl/irq_bypass_pkg.sv
// Shared constants and helpers for the interrupt bypass selector.
// Assumes byte-wide write lanes; channel numbering starts at 1.
package irq_bypass_pkg;
    localparam int LANE_W = 8;

    // Number of byte lanes needed to hold one bypass bit per channel.
    function automatic int lanes_for(input int n_ch);
        return (n_ch + LANE_W - 1) / LANE_W;
    endfunction

    // Width of a binary channel number able to hold 0..n_ch.
    function automatic int ch_width(input int n_ch);
        return $clog2(n_ch + 1);
    endfunction
endpackage

// File: rtl/irq_bypass_ctrl.sv
// Bypass control register: one bit per channel (1 = forward to output,
// hidden from the coprocessor). Written through byte lanes; bit c-1 of the
// write data belongs to channel c. Assumes synchronous active-low reset,
// which sets every bit.
module irq_bypass_ctrl
    import irq_bypass_pkg::*;
#(
    parameter int NUM_CH = 16,
    localparam int LANES = lanes_for(NUM_CH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [LANES-1:0]        wr_be,
    input  logic [LANE_W*LANES-1:0] wr_data,
    output logic [NUM_CH:1]         byp
);
    for (genvar c = 1; c <= NUM_CH; c++) begin : g_bit
        localparam int LANE = (c - 1) / LANE_W;
        // Load this channel's bit when its lane is enabled.
        always_ff @(posedge clk) begin
            if (!rst_n)
                byp[c] <= 1'b1;
            else if (wr_en && wr_be[LANE])
                byp[c] <= wr_data[c-1];
        end
    end

    if (LANE_W * LANES > NUM_CH) begin : g_pad
        logic pad_unused;
        // Data bits beyond the last channel have no register behind them.
        assign pad_unused = ^wr_data[LANE_W*LANES-1:NUM_CH];
    end
endmodule

// File: rtl/irq_bypass_gate.sv
// Splits each request into a forwarded copy (bypass set) and a copy
// eligible for the coprocessor (bypass clear). Purely combinational.
module irq_bypass_gate #(
    parameter int NUM_CH = 16
) (
    input  logic [NUM_CH:1] req,
    input  logic [NUM_CH:1] byp,
    output logic [NUM_CH:1] fwd,
    output logic [NUM_CH:1] elig
);
    // Steer each request to exactly one of the two destinations.
    always_comb begin
        fwd  = req & byp;
        elig = req & ~byp;
    end
endmodule

// File: rtl/irq_bypass_prio.sv
// Registered priority encoder: the lowest-numbered eligible channel wins.
// Reports channel number 0 with valid low when nothing is eligible.
// Assumes channels numbered 1..NUM_CH; synchronous active-low reset.
module irq_bypass_prio
    import irq_bypass_pkg::*;
#(
    parameter int NUM_CH = 16,
    localparam int CH_W = ch_width(NUM_CH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NUM_CH:1] elig,
    output logic            valid,
    output logic [CH_W-1:0] ch
);
    logic            nxt_valid;
    logic [CH_W-1:0] nxt_ch;

    // Scan from the top down so the lowest eligible index is kept last.
    always_comb begin
        nxt_valid = 1'b0;
        nxt_ch    = '0;
        for (int i = NUM_CH; i >= 1; i--) begin
            if (elig[i]) begin
                nxt_valid = 1'b1;
                nxt_ch    = CH_W'(i);
            end
        end
    end

    // Hold the selection for one cycle of latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            ch    <= '0;
        end else begin
            valid <= nxt_valid;
            ch    <= nxt_ch;
        end
    end
endmodule

// File: rtl/irq_bypass_sel.sv
// Top of the interrupt bypass selector. Requests whose bypass bit is set go
// straight to irq_out; the others compete for the coprocessor, lowest
// channel first. Channel 0 does not exist. All channels start bypassed.
module irq_bypass_sel
    import irq_bypass_pkg::*;
#(
    parameter int NUM_CH = 16,
    localparam int LANES = lanes_for(NUM_CH),
    localparam int CH_W  = ch_width(NUM_CH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [LANES-1:0]        wr_be,
    input  logic [LANE_W*LANES-1:0] wr_data,
    input  logic [NUM_CH:1]         irq_in,
    output logic [NUM_CH:1]         irq_out,
    output logic                    sel_valid,
    output logic [CH_W-1:0]         sel_ch
);
    logic [NUM_CH:1] byp;
    logic [NUM_CH:1] elig;

    irq_bypass_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_be   (wr_be),
        .wr_data (wr_data),
        .byp     (byp)
    );

    irq_bypass_gate #(.NUM_CH(NUM_CH)) u_gate (
        .req  (irq_in),
        .byp  (byp),
        .fwd  (irq_out),
        .elig (elig)
    );

    irq_bypass_prio #(.NUM_CH(NUM_CH)) u_prio (
        .clk   (clk),
        .rst_n (rst_n),
        .elig  (elig),
        .valid (sel_valid),
        .ch    (sel_ch)
    );
endmodule

// File: rtl/irq_bypass_sel_chk.sv
// Checker bound to irq_bypass_sel. It sees the ports only; the state from the
// previous edge is rebuilt from registered copies of irq_in and irq_out.
module irq_bypass_sel_chk #(
    parameter int NUM_CH = 16,
    parameter int CH_W   = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NUM_CH:1] irq_in,
    input logic [NUM_CH:1] irq_out,
    input logic            sel_valid,
    input logic [CH_W-1:0] sel_ch
);
    logic [NUM_CH:1] in_q;
    logic [NUM_CH:1] out_q;
    logic [NUM_CH:1] below;
    logic            started;

    // Record the port values seen at each edge.
    always_ff @(posedge clk) begin
        in_q    <= irq_in;
        out_q   <= irq_out;
        started <= rst_n;
    end

    // Mask of channel numbers lower than the one selected.
    always_comb begin
        for (int i = 1; i <= NUM_CH; i++)
            below[i] = (i < int'(sel_ch));
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!sel_valid && sel_ch == '0 && irq_out == irq_in));

    // R2
    fwd_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out & ~irq_in) == '0);

    // R3
    bypassed_not_sel_chk: assert property (@(posedge clk) disable iff (!rst_n || !started)
        sel_valid |-> (in_q[sel_ch] && !out_q[sel_ch]));

    // R4
    lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n || !started)
        sel_valid |-> ((in_q & ~out_q & below) == '0));

    // R5
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n || !started)
        ((in_q & ~out_q) == '0) |-> (!sel_valid && sel_ch == '0));

    // R9
    ch_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> (sel_ch != '0 && int'(sel_ch) <= NUM_CH));
endmodule

bind irq_bypass_sel irq_bypass_sel_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .irq_out   (irq_out),
    .sel_valid (sel_valid),
    .sel_ch    (sel_ch)
);

// File: tb/irq_bypass_sel_bench.sv
// Directed bench for irq_bypass_sel: one task per scenario, each checking
// its own results against a bench-side model of the bypass bits.
module irq_bypass_sel_bench;
    localparam int NUM_CH = 16;
    localparam int LANES  = 2;
    localparam int CH_W   = 5;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic                 wr_en;
    logic [LANES-1:0]     wr_be;
    logic [8*LANES-1:0]   wr_data;
    logic [NUM_CH:1]      irq_in;
    logic [NUM_CH:1]      irq_out;
    logic                 sel_valid;
    logic [CH_W-1:0]      sel_ch;

    logic [NUM_CH:1]      byp_m;
    int                   n_chk  = 0;
    int                   n_fail = 0;

    always #2.5 clk = ~clk;

    irq_bypass_sel #(.NUM_CH(NUM_CH)) u_irq_bypass_sel (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be),
        .wr_data(wr_data), .irq_in(irq_in), .irq_out(irq_out),
        .sel_valid(sel_valid), .sel_ch(sel_ch)
    );

    // Expected selection: lowest requesting channel with bypass clear.
    function automatic int exp_sel(input logic [NUM_CH:1] r, input logic [NUM_CH:1] b);
        for (int i = 1; i <= NUM_CH; i++)
            if (r[i] && !b[i]) return i;
        return 0;
    endfunction

    task automatic chk(input string req, input logic ok, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Compare irq_out with the model (R2 behaviour).
    task automatic chk_fwd(input string req);
        chk(req, irq_out == (irq_in & byp_m), int'(irq_out), int'(irq_in & byp_m));
    endtask

    // Compare the selection against the given inputs and bypass bits.
    task automatic chk_sel(input string req, input logic [NUM_CH:1] r, input logic [NUM_CH:1] b);
        int e = exp_sel(r, b);
        chk(req, (sel_valid == (e != 0)) && (int'(sel_ch) == e),
            {int'(sel_valid), int'(sel_ch)} == 0 ? 0 : (int'(sel_valid) << 8) | int'(sel_ch),
            ((e != 0) << 8) | e);
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Write bypass bits; returns at the negedge after the write edge.
    task automatic wr_byp(input logic en, input logic [LANES-1:0] be, input logic [8*LANES-1:0] d);
        wr_en = en; wr_be = be; wr_data = d;
        @(posedge clk);
        if (en)
            for (int c = 1; c <= NUM_CH; c++)
                if (be[(c-1)/8]) byp_m[c] = d[c-1];
        @(negedge clk);
        wr_en = 1'b0; wr_be = '0; wr_data = '0;
    endtask

    task automatic t_reset();
        irq_in = 16'hA5C3;
        tick();
        chk_fwd("R1");
        chk("R1", !sel_valid && sel_ch == '0, {sel_valid, sel_ch}, 0);
        rst_n = 1'b1;
        tick();
        chk_fwd("R1");
    endtask

    task automatic t_all_bypassed();
        irq_in = '1;
        tick();
        chk("R3", !sel_valid, int'(sel_valid), 0);
        chk_fwd("R2");
    endtask

    task automatic t_lane_write();
        wr_byp(1'b1, 2'b01, 16'hFF00);
        irq_in = 16'h8181;
        tick();
        chk_fwd("R6");
        chk("R6", irq_out == 16'h8100, int'(irq_out), 16'h8100);
        chk_sel("R3", irq_in, byp_m);
    endtask

    task automatic t_wr_disabled();
        wr_byp(1'b0, 2'b11, 16'h0000);
        tick();
        chk("R7", irq_out == 16'h8100, int'(irq_out), 16'h8100);
        wr_byp(1'b1, 2'b00, 16'h0000);
        tick();
        chk("R7", irq_out == 16'h8100, int'(irq_out), 16'h8100);
    endtask

    task automatic t_priority();
        irq_in = 16'h0014; tick(); chk_sel("R4", irq_in, byp_m);
        chk("R4", sel_ch == 5'd3, int'(sel_ch), 3);
        irq_in = 16'h0080; tick(); chk_sel("R4", irq_in, byp_m);
        chk("R9", sel_valid && sel_ch == 5'd8, int'(sel_ch), 8);
        wr_byp(1'b1, 2'b10, 16'h0000);
        irq_in = 16'h8800; tick(); chk_sel("R4", irq_in, byp_m);
        chk("R4", sel_ch == 5'd12, int'(sel_ch), 12);
        irq_in = 16'h8001; tick(); chk_sel("R4", irq_in, byp_m);
        chk("R9", sel_ch == 5'd1, int'(sel_ch), 1);
        irq_in = 16'h0100; tick(); chk_sel("R4", irq_in, byp_m);
        irq_in = 16'h8000; tick(); chk_sel("R9", irq_in, byp_m);
    endtask

    task automatic t_none();
        irq_in = '0; tick();
        chk("R5", !sel_valid && sel_ch == '0, {sel_valid, sel_ch}, 0);
        chk_fwd("R5");
    endtask

    task automatic t_latency();
        logic [NUM_CH:1] prev;
        irq_in = 16'h0040; tick();
        prev = irq_in;
        irq_in = 16'h0002; #1;
        chk_sel("R8", prev, byp_m);
        @(negedge clk);
        chk("R8", sel_ch == 5'd2, int'(sel_ch), 2);
        // Re-bypass channel 2 while it requests.
        prev = byp_m;
        wr_byp(1'b1, 2'b01, 16'h0002);
        chk("R8", irq_out == 16'h0002, int'(irq_out), 2);
        chk_sel("R8", irq_in, prev);
        tick();
        chk_sel("R8", irq_in, byp_m);
        chk("R3", !sel_valid, int'(sel_valid), 0);
    endtask

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_be = '0; wr_data = '0; irq_in = '0;
        byp_m = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        t_all_bypassed();
        t_lane_write();
        t_wr_disabled();
        t_priority();
        t_none();
        t_latency();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #100000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule